// File: doc/BRIEF.md
# Register-Mapped CRC-32 Engine with Completion Interrupt

This block computes a CRC-32 over a short message on behalf of a processor. Software fills an on-block message buffer through plain register writes, sets the byte count and then writes the start bit. The engine walks the buffer one byte per clock. It writes the final checksum into a result register and raises a level interrupt that stays up until software acknowledges it. The checksum is meant to be appended by software after the payload it covers.

The register port is a single-cycle address/write-enable/data interface with a combinational read path. There is one control word, one status word, a length word, a result word and a word-addressed message buffer.

Top module: `crc_acc`

## Requirements
- R1: After reset the status word (0x04) reads 0, the length (0x08) reads 0, the result (0x0C) reads 0 and irq_o is low.
- R2: The result is the reflected CRC-32: polynomial 0x04C11DB7, start value 0xFFFFFFFF, input and output reflected, final XOR 0xFFFFFFFF. For the ASCII bytes "123456789" it is 0xCBF43926. Message byte k is bits [8*(k%4)+7 : 8*(k%4)] of the buffer word at address 0x100+4*(k/4). Bytes are taken in increasing k.
- R3: A write to 0x00 with bit 0 set while the engine is idle starts a run. From the cycle after the run starts, bit 0 of 0x00 reads 0 and bit 0 of 0x04 (busy) reads 1 until the run ends.
- R4: For a length of N bytes, busy falls and status bit 1 (done) and irq_o rise exactly N+1 clock edges after the edge that takes the start write. The result is readable at 0x0C from then on.
- R5: irq_o is a level that mirrors done. It stays high until a write to 0x00 with bit 1 set, and that write clears both irq_o and status bit 1.
- R6: While busy, writes to the buffer and start requests are ignored. Buffer words read back their old value, and no second run follows.
- R7: A length of 0 completes one edge after the start write, with the result 0x00000000.
- R8: A length write above the buffer size (64 bytes) stores 64. The stored length reads back at 0x08.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW (9) | Byte address of the register access |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Completion interrupt, level, held until cleared |

## Verification
The bench builds the block with its default 64-byte buffer and 9-bit address. This puts the full-buffer run, the length clamp at 64 and the whole buffer address window within reach of a short run. Random messages of 1 to 64 bytes are checked against a bench bit-serial CRC, together with the standard check string, the zero-length case and the exact completion latency. A busy run is hit with buffer and start writes to show both are dropped.

// File: rtl/crc_acc_pkg.sv
`timescale 1ns/1ps
package crc_acc_pkg;
  localparam int unsigned OFF_CTRL = 32'h00;
  localparam int unsigned OFF_STAT = 32'h04;
  localparam int unsigned OFF_LEN  = 32'h08;
  localparam int unsigned OFF_RES  = 32'h0C;
  localparam int unsigned BUF_BASE = 32'h100;

  localparam logic [31:0] CRC_INIT   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_XOUT   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320; // 0x04C11DB7 bit-reversed

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/crc_acc_buf.sv
`timescale 1ns/1ps
module crc_acc_buf #(
  parameter int unsigned BUF_BYTES = 64,
  localparam int unsigned WORDS = BUF_BYTES / 4,
  localparam int unsigned IW    = $clog2(BUF_BYTES),
  localparam int unsigned WIW   = IW - 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [WIW-1:0] widx_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    wrd_o,
  input  logic [IW-1:0]  bidx_i,
  output logic [7:0]     byte_o
);
  logic [WORDS-1:0][31:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (wr_en_i) mem_q[widx_i] <= wdata_i;
  end

  assign wrd_o  = mem_q[widx_i];
  assign byte_o = mem_q[bidx_i[IW-1:2]][{bidx_i[1:0], 3'b000} +: 8];

  // R6
  buf_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_q));
endmodule

// File: rtl/crc_acc_seq.sv
`timescale 1ns/1ps
module crc_acc_seq #(
  parameter int unsigned LW = 7,
  parameter int unsigned IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          finish_o
);
  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic [LW-1:0] len_q;
  logic          last;

  assign last     = busy_q && (LW'(idx_q) + LW'(1) == len_q);
  assign finish_o = (start_i && len_i == '0) || last;
  assign busy_o   = busy_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
    end else if (start_i && len_i != '0) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      len_q  <= len_i;  // latched: length writes mid-run do not disturb it
    end else if (busy_q) begin
      idx_q <= idx_q + IW'(1);
      if (last) busy_q <= 1'b0;
    end
  end

  // R4
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (LW'(idx_q) < len_q));
endmodule

// File: rtl/crc_acc_engine.sv
`timescale 1ns/1ps
module crc_acc_engine
  import crc_acc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        step_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] nxt_o
);
  logic [31:0] crc_q;

  assign nxt_o = crc_byte(crc_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (init_i) crc_q <= CRC_INIT;
    else if (step_i) crc_q <= nxt_o;
  end
endmodule

// File: rtl/crc_acc.sv
`timescale 1ns/1ps
module crc_acc
  import crc_acc_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned AW        = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o
);
  localparam int unsigned IW  = $clog2(BUF_BYTES);
  localparam int unsigned WIW = IW - 2;
  localparam int unsigned LW  = $clog2(BUF_BYTES + 1);
  localparam logic [AW-1:0] BASE = AW'(BUF_BASE);

  logic          hit_ctrl, hit_stat, hit_len, hit_res, hit_buf;
  logic          wr_ctrl, clr_req;
  logic          en_q, done_q, start;
  logic [LW-1:0] len_q;
  logic [31:0]   result_q;
  logic          seq_busy, seq_finish;
  logic [IW-1:0] seq_idx;
  logic [7:0]    cur_byte;
  logic [31:0]   eng_nxt, buf_rd;

  assign hit_ctrl = addr_i == AW'(OFF_CTRL);
  assign hit_stat = addr_i == AW'(OFF_STAT);
  assign hit_len  = addr_i == AW'(OFF_LEN);
  assign hit_res  = addr_i == AW'(OFF_RES);
  assign hit_buf  = addr_i[AW-1:IW] == BASE[AW-1:IW];

  assign wr_ctrl = we_i && hit_ctrl;
  assign clr_req = wr_ctrl && wdata_i[1];
  assign start   = en_q && !seq_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      done_q   <= 1'b0;
      len_q    <= '0;
      result_q <= '0;
    end else begin
      // enable bit lives one cycle, then self-clears as the run starts
      en_q <= wr_ctrl && wdata_i[0] && !seq_busy && !en_q;
      if (seq_finish) begin
        done_q   <= 1'b1;
        result_q <= seq_busy ? (eng_nxt ^ CRC_XOUT) : (CRC_INIT ^ CRC_XOUT);
      end else if (clr_req) begin
        done_q <= 1'b0;
      end
      if (we_i && hit_len)
        len_q <= (wdata_i > 32'(BUF_BYTES)) ? LW'(BUF_BYTES) : wdata_i[LW-1:0];
    end
  end

  crc_acc_buf #(.BUF_BYTES(BUF_BYTES)) i_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (we_i && hit_buf && !seq_busy),
    .widx_i  (addr_i[IW-1:2]),
    .wdata_i (wdata_i),
    .wrd_o   (buf_rd),
    .bidx_i  (seq_idx),
    .byte_o  (cur_byte)
  );

  crc_acc_seq #(.LW(LW), .IW(IW)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .len_i    (len_q),
    .busy_o   (seq_busy),
    .idx_o    (seq_idx),
    .finish_o (seq_finish)
  );

  crc_acc_engine i_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (start),
    .step_i (seq_busy),
    .byte_i (cur_byte),
    .nxt_o  (eng_nxt)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl)      rdata_o = {31'b0, en_q};
    else if (hit_stat) rdata_o = {30'b0, done_q, seq_busy};
    else if (hit_len)  rdata_o = 32'(len_q);
    else if (hit_res)  rdata_o = result_q;
    else if (hit_buf)  rdata_o = buf_rd;
  end

  assign irq_o = done_q;

  // R3
  en_selfclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> !en_q);
  // R5
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_req) |=> irq_o);
  // R7
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && len_q == '0) |=> (irq_o && result_q == 32'h0 && !seq_busy));
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !seq_busy);
  // R8
  len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(len_q) <= 32'(BUF_BYTES));
endmodule

// File: tb/test_crc_acc.sv
`timescale 1ns/1ps
module test_crc_acc;
  localparam int AW = 9;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] msg [64];

  always #10 clk = ~clk;

  crc_acc i_crc_acc (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ msg[k][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return ~c;
  endfunction

  task automatic load_msg();
    for (int w = 0; w < 16; w++)
      wr(32'h100 + 4*w, {msg[4*w+3], msg[4*w+2], msg[4*w+1], msg[4*w]});
  endtask

  // start a run of n bytes, count edges to irq, check result and clear
  task automatic run_msg(input int n, input string tag);
    logic [31:0] d;
    int k;
    wr(8, n);
    wr(0, 32'h1);
    k = 0;
    while (!irq && k < 200) begin @(negedge clk); k++; end
    check(k == n + 1, "R4 latency", k, n + 1);
    rd(12, d);
    check(d == ref_crc(n), tag, d, ref_crc(n));
    rd(4, d);
    check(d == 32'h2, "R4 status done", d, 32'h2);
    wr(0, 32'h2);
    check(irq == 1'b0, "R5 irq cleared", {31'b0, irq}, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, keep0;
    string s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4, d);  check(d == 0, "R1 status", d, 0);
    rd(8, d);  check(d == 0, "R1 length", d, 0);
    rd(12, d); check(d == 0, "R1 result", d, 0);
    check(irq == 0, "R1 irq", {31'b0, irq}, 0);

    // R2 standard check string
    s = "123456789";
    for (int i = 0; i < 64; i++) msg[i] = (i < 9) ? s[i] : 8'h00;
    load_msg();
    run_msg(9, "R2 crc");
    rd(12, d); check(d == 32'hCBF4_3926, "R2 check value", d, 32'hCBF4_3926);

    // R7 zero length
    run_msg(0, "R7 zero crc");
    rd(12, d); check(d == 32'h0, "R7 zero result", d, 0);

    // R8 length clamp
    wr(8, 200); rd(8, d); check(d == 64, "R8 clamp", d, 64);
    wr(8, 64);  rd(8, d); check(d == 64, "R8 max", d, 64);
    wr(8, 37);  rd(8, d); check(d == 37, "R8 normal", d, 37);

    // full buffer, random data
    for (int i = 0; i < 64; i++) msg[i] = 8'($urandom);
    load_msg();
    run_msg(64, "R2 full buffer");

    // R3/R6: busy behaviour
    for (int i = 0; i < 64; i++) msg[i] = 8'($urandom);
    load_msg();
    keep0 = {msg[3], msg[2], msg[1], msg[0]};
    wr(8, 40);
    wr(0, 32'h1);
    @(negedge clk);
    rd(0, d); check(d == 0, "R3 enable self-clear", d, 0);
    rd(4, d); check(d == 32'h1, "R3 busy", d, 1);
    wr(32'h100, ~keep0);
    wr(32'h13C, 32'hA5A5_A5A5);
    wr(0, 32'h1);
    while (!irq) @(negedge clk);
    rd(32'h100, d); check(d == keep0, "R6 buffer write ignored", d, keep0);
    rd(32'h13C, d);
    check(d == {msg[63], msg[62], msg[61], msg[60]}, "R6 buffer tail kept", d, {msg[63], msg[62], msg[61], msg[60]});
    rd(12, d); check(d == ref_crc(40), "R2 crc after busy writes", d, ref_crc(40));
    repeat (5) @(negedge clk);
    rd(4, d); check(d == 32'h2, "R6 no second run", d, 32'h2);

    // R5 irq holds until clear
    repeat (10) @(negedge clk);
    check(irq == 1, "R5 irq held", {31'b0, irq}, 1);
    wr(0, 32'h0);
    check(irq == 1, "R5 irq held after write without clear bit", {31'b0, irq}, 1);
    wr(0, 32'h2);
    check(irq == 0, "R5 irq clear", {31'b0, irq}, 0);
    rd(4, d); check(d == 0, "R5 done cleared", d, 0);

    // random lengths and data
    for (int t = 0; t < 8; t++) begin
      int n;
      n = 1 + int'($urandom_range(63));
      for (int i = 0; i < 64; i++) msg[i] = 8'($urandom);
      load_msg();
      run_msg(n, "R2 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule